// File: doc/BRIEF.md
# Programmable Two-Term Boolean Output Driver

This block drives one general-purpose output pin from a Boolean expression that can be configured. The expression is the OR of two product terms. Each term can AND together any subset of three kinds of inputs, and each input has its own invert bit. The first kind is the logical states of up to eight other outputs. The second is the input pins. The third is the per-rail flags of one status type that the term chooses.

Every status type exists in two forms. The live form follows the rail flags as they arrive. The latched form is sticky: it is set when a flag rises and holds until a clear strobe arrives, or until a chosen input pin is asserted.

The undelayed result is registered and exposed as the logical state, which other logic uses as a dependency. The pin copy of that state can be held back by separate assertion and deassertion delays, counted in 1 ms ticks.

Top module: `sop_gpo_top`

## Requirements
- R1: While reset is held and on the first cycle after it is released, `logic_o` and `pin_o` are 0 and every latched flag is clear.
- R2: `logic_o` equals, one clock after the inputs are sampled, the OR of the two product terms. Term t takes its configuration from bit slice t of every per-term configuration vector.
- R3: A product term is 1 only when it has at least one enabled input and every enabled input, XORed with its invert bit, is 1. A term with no enabled input is 0 whatever its invert bits are.
- R4: Bits [3:0] of a term's 5-bit type select pick the status type index, and bit 4 picks the latched form (1) or the live form (0). The flag of type k for rail r sits at bit k*N_RAIL+r of `rail_flags_i`. A rail takes part in a term when its mask bit is set. A type index at or above NUM_TYPES reads as flags of 0.
- R5: Type index 0 is power-good. With that type selected, a rail whose `rail_vmon_i` bit is 0 is left out of the term even when its mask bit is set.
- R6: A latched flag is set on the clock edge where its live flag is 1 and was 0 on the previous edge. It then stays set.
- R7: All latched flags clear on an edge where `latch_clr_i` is 1, or where `cfg_clr_gpi_en_i` is 1 and the input pin indexed by `cfg_clr_gpi_sel_i` is 1. An index at or above N_GPI clears nothing. A rise on the same edge wins over the clear.
- R8: When `logic_o` differs from `pin_o`, the delay for the new level applies: the on delay when rising, the off delay when falling. If that delay is disabled or zero, `pin_o` copies `logic_o` on the next edge. Otherwise `pin_o` copies it on the edge that samples the D-th tick seen while the two differ, where D is the delay value.
- R9: If `logic_o` returns to the value of `pin_o` before the delay expires, the count is discarded and `pin_o` does not change. A later change starts a full new delay.
- R10: `logic_o` is never delayed by the pin delays; it follows R2 even while `pin_o` is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1ms_i | input | 1 | One-cycle delay tick strobe |
| gpo_state_i | input | N_GPO | Logical states of other outputs |
| gpi_i | input | N_GPI | Input pin levels |
| rail_flags_i | input | NUM_TYPES*N_RAIL | Live status flags, type-major |
| rail_vmon_i | input | N_RAIL | 1 where the rail has voltage monitoring |
| latch_clr_i | input | 1 | Clear strobe for all latched flags |
| cfg_gpo_en_i | input | 2*N_GPO | Per-term output-state enables |
| cfg_gpo_inv_i | input | 2*N_GPO | Per-term output-state inverts |
| cfg_gpi_en_i | input | 2*N_GPI | Per-term input-pin enables |
| cfg_gpi_inv_i | input | 2*N_GPI | Per-term input-pin inverts |
| cfg_rail_mask_i | input | 2*N_RAIL | Per-term rail masks |
| cfg_rail_inv_i | input | 2*N_RAIL | Per-term rail-flag inverts |
| cfg_type_sel_i | input | 10 | Per-term 5-bit status-type select |
| cfg_clr_gpi_en_i | input | 1 | Enables an input pin as clear source |
| cfg_clr_gpi_sel_i | input | 4 | Index of the clear-source input pin |
| cfg_on_dly_i | input | 16 | Assertion delay in ticks |
| cfg_off_dly_i | input | 16 | Deassertion delay in ticks |
| cfg_on_dly_en_i | input | 1 | Assertion delay enable |
| cfg_off_dly_en_i | input | 1 | Deassertion delay enable |
| logic_o | output | 1 | Registered undelayed logical state |
| pin_o | output | 1 | Delayed output pin |

## Verification
The bench builds the block with eight output states, three input pins, three rails and six status types. Six types leave type indices 6 to 15 out of range, so the zero-flag rule for unused type indices is exercised. Three input pins make the clear-source index 3 point at a pin that does not exist. Small delay values from 0 to 4, with a random tick strobe, let assertion, deassertion, restart and pass-through all occur many times within a short run.

// File: rtl/sop_gpo_pkg.sv
// Package: shared constants for the two-term Boolean output driver.
// Assumes at most 16 status types and at most 16 input pins.
package sop_gpo_pkg;
    localparam int NUM_TERMS  = 2;
    localparam int TYPE_IDX_W = 4;
    localparam int SEL_W      = TYPE_IDX_W + 1;
    localparam int PG_TYPE    = 0;
    localparam int DLY_W      = 16;
    localparam int CLR_SEL_W  = 4;

    typedef logic [DLY_W-1:0] dly_t;
endpackage

// File: rtl/sop_sticky_bank.sv
// Sticky flag bank: one latch per rail per status type. A latch is set on a
// rising live flag and cleared by clr_i; a rise on the same edge wins.
// Assumes live_i is synchronous to clk.
module sop_sticky_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] live_i,
    input  logic         clr_i,
    output logic [W-1:0] lat_o
);
    logic [W-1:0] prev_q;
    logic [W-1:0] lat_q;
    logic [W-1:0] rise;

    // Purpose: find live flags that were low on the previous edge.
    always_comb rise = live_i & ~prev_q;

    // Purpose: hold previous live flags and the sticky latches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            lat_q  <= '0;
        end else begin
            prev_q <= live_i;
            lat_q  <= (lat_q & ~{W{clr_i}}) | rise;
        end
    end

    assign lat_o = lat_q;
endmodule

// File: rtl/sop_rail_pick.sv
// Rail picker: selects one status type (live or latched) for one product
// term and reports which rails take part. Power-good rails without voltage
// monitoring are excluded. Type indices beyond NUM_TYPES read as zero.
module sop_rail_pick
    import sop_gpo_pkg::*;
#(
    parameter int N_RAIL    = 4,
    parameter int NUM_TYPES = 16
) (
    input  logic [NUM_TYPES*N_RAIL-1:0] live_i,
    input  logic [NUM_TYPES*N_RAIL-1:0] lat_i,
    input  logic [SEL_W-1:0]            sel_i,
    input  logic [N_RAIL-1:0]           mask_i,
    input  logic [N_RAIL-1:0]           vmon_i,
    output logic [N_RAIL-1:0]           flag_o,
    output logic [N_RAIL-1:0]           use_o
);
    logic [TYPE_IDX_W-1:0] idx;
    logic                  want_lat;

    // Purpose: split the select into type index and form.
    always_comb begin
        idx      = sel_i[TYPE_IDX_W-1:0];
        want_lat = sel_i[SEL_W-1];
    end

    // Purpose: multiplex the chosen type's flags for every rail.
    always_comb begin
        flag_o = '0;
        for (int t = 0; t < NUM_TYPES; t++) begin
            if (idx == TYPE_IDX_W'(t)) begin
                flag_o = want_lat ? lat_i[t*N_RAIL +: N_RAIL]
                                  : live_i[t*N_RAIL +: N_RAIL];
            end
        end
    end

    // Purpose: mask rails, dropping unmonitored rails for power-good.
    always_comb begin
        if (idx == TYPE_IDX_W'(PG_TYPE)) use_o = mask_i & vmon_i;
        else                              use_o = mask_i;
    end
endmodule

// File: rtl/sop_product_term.sv
// Product term: AND of enabled inputs, each optionally inverted.
// An empty term (no enables) yields 0.
module sop_product_term #(
    parameter int W = 8
) (
    input  logic [W-1:0] in_i,
    input  logic [W-1:0] en_i,
    input  logic [W-1:0] inv_i,
    output logic         term_o
);
    logic any_en;
    logic all_ok;

    // Purpose: AND the enabled, polarity-corrected inputs.
    always_comb begin
        any_en = |en_i;
        all_ok = &((in_i ^ inv_i) | ~en_i);
        term_o = any_en & all_ok;
    end
endmodule

// File: rtl/sop_edge_delay.sv
// Edge delay: pin follows level_i after an on or off delay counted in
// ticks. Returning to the pin value discards the count. A disabled or zero
// delay passes the change on the next edge.
module sop_edge_delay #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          level_i,
    input  logic [DW-1:0] on_dly_i,
    input  logic [DW-1:0] off_dly_i,
    input  logic          on_en_i,
    input  logic          off_en_i,
    output logic          pin_o
);
    logic [DW-1:0] cnt_q;
    logic [DW-1:0] dly_val;
    logic          dly_act;
    logic          pass_now;
    logic          pin_q;

    // Purpose: pick the delay that applies to the pending transition.
    always_comb begin
        dly_val  = level_i ? on_dly_i : off_dly_i;
        dly_act  = level_i ? on_en_i  : off_en_i;
        pass_now = !dly_act || (dly_val == '0);
    end

    // Purpose: count ticks while level and pin differ, then update the pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q <= 1'b0;
            cnt_q <= '0;
        end else if (level_i == pin_q) begin
            cnt_q <= '0;
        end else if (pass_now) begin
            pin_q <= level_i;
            cnt_q <= '0;
        end else if (tick_i) begin
            if ((cnt_q + DW'(1)) >= dly_val) begin
                pin_q <= level_i;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + DW'(1);
            end
        end
    end

    assign pin_o = pin_q;
endmodule

// File: rtl/sop_gpo_top.sv
// Two-term Boolean output driver. Evaluates (term0 | term1) from output
// states, input pins and one chosen rail-status type per term, registers the
// result as the logical state, and drives the pin through on/off delays.
// Assumes all inputs are synchronous to clk; tick_1ms_i is a one-cycle pulse.
module sop_gpo_top
    import sop_gpo_pkg::*;
#(
    parameter int N_GPO     = 8,
    parameter int N_GPI     = 4,
    parameter int N_RAIL    = 4,
    parameter int NUM_TYPES = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          tick_1ms_i,
    input  logic [N_GPO-1:0]              gpo_state_i,
    input  logic [N_GPI-1:0]              gpi_i,
    input  logic [NUM_TYPES*N_RAIL-1:0]   rail_flags_i,
    input  logic [N_RAIL-1:0]             rail_vmon_i,
    input  logic                          latch_clr_i,
    input  logic [NUM_TERMS*N_GPO-1:0]    cfg_gpo_en_i,
    input  logic [NUM_TERMS*N_GPO-1:0]    cfg_gpo_inv_i,
    input  logic [NUM_TERMS*N_GPI-1:0]    cfg_gpi_en_i,
    input  logic [NUM_TERMS*N_GPI-1:0]    cfg_gpi_inv_i,
    input  logic [NUM_TERMS*N_RAIL-1:0]   cfg_rail_mask_i,
    input  logic [NUM_TERMS*N_RAIL-1:0]   cfg_rail_inv_i,
    input  logic [NUM_TERMS*SEL_W-1:0]    cfg_type_sel_i,
    input  logic                          cfg_clr_gpi_en_i,
    input  logic [CLR_SEL_W-1:0]          cfg_clr_gpi_sel_i,
    input  logic [DLY_W-1:0]              cfg_on_dly_i,
    input  logic [DLY_W-1:0]              cfg_off_dly_i,
    input  logic                          cfg_on_dly_en_i,
    input  logic                          cfg_off_dly_en_i,
    output logic                          logic_o,
    output logic                          pin_o
);
    localparam int FLAG_W = NUM_TYPES * N_RAIL;
    localparam int TERM_W = N_RAIL + N_GPI + N_GPO;

    logic [FLAG_W-1:0]    lat_q;
    logic                 clr_pin;
    logic                 clr_any;
    logic [NUM_TERMS-1:0] term_val;
    logic                 logic_q;

    // Purpose: pick the clear-source pin and merge it with the strobe.
    always_comb begin
        clr_pin = 1'b0;
        for (int i = 0; i < N_GPI; i++) begin
            if (cfg_clr_gpi_sel_i == CLR_SEL_W'(i)) clr_pin = gpi_i[i];
        end
        clr_any = latch_clr_i | (cfg_clr_gpi_en_i & clr_pin);
    end

    sop_sticky_bank #(.W(FLAG_W)) u_sticky (
        .clk    (clk),
        .rst_n  (rst_n),
        .live_i (rail_flags_i),
        .clr_i  (clr_any),
        .lat_o  (lat_q)
    );

    for (genvar t = 0; t < NUM_TERMS; t++) begin : g_term
        logic [N_RAIL-1:0] rail_vec;
        logic [N_RAIL-1:0] rail_use;

        sop_rail_pick #(.N_RAIL(N_RAIL), .NUM_TYPES(NUM_TYPES)) u_pick (
            .live_i (rail_flags_i),
            .lat_i  (lat_q),
            .sel_i  (cfg_type_sel_i[t*SEL_W +: SEL_W]),
            .mask_i (cfg_rail_mask_i[t*N_RAIL +: N_RAIL]),
            .vmon_i (rail_vmon_i),
            .flag_o (rail_vec),
            .use_o  (rail_use)
        );

        sop_product_term #(.W(TERM_W)) u_and (
            .in_i  ({rail_vec, gpi_i, gpo_state_i}),
            .en_i  ({rail_use,
                     cfg_gpi_en_i[t*N_GPI +: N_GPI],
                     cfg_gpo_en_i[t*N_GPO +: N_GPO]}),
            .inv_i ({cfg_rail_inv_i[t*N_RAIL +: N_RAIL],
                     cfg_gpi_inv_i[t*N_GPI +: N_GPI],
                     cfg_gpo_inv_i[t*N_GPO +: N_GPO]}),
            .term_o(term_val[t])
        );
    end

    // Purpose: register the undelayed sum of products.
    always_ff @(posedge clk) begin
        if (!rst_n) logic_q <= 1'b0;
        else        logic_q <= |term_val;
    end

    sop_edge_delay #(.DW(DLY_W)) u_delay (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_1ms_i),
        .level_i   (logic_q),
        .on_dly_i  (cfg_on_dly_i),
        .off_dly_i (cfg_off_dly_i),
        .on_en_i   (cfg_on_dly_en_i),
        .off_en_i  (cfg_off_dly_en_i),
        .pin_o     (pin_o)
    );

    assign logic_o = logic_q;
endmodule

// File: rtl/sop_gpo_chk.sv
// Checker for sop_gpo_top: relates logical state, pin and latches over time.
module sop_gpo_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         logic_o,
    input logic         pin_o,
    input logic         cfg_on_dly_en_i,
    input logic [W-1:0] lat_q,
    input logic         clr_any
);
    // R1: outputs idle right after reset release
    a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!logic_o && !pin_o && (lat_q == '0)));

    // R8: the pin only ever moves to the previous logical state
    a_r8_pin_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_o != $past(pin_o)) |-> (pin_o == $past(logic_o)));

    // R8: disabled on delay passes a rise on the next edge
    a_r8_on_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        $past(logic_o && !pin_o && !cfg_on_dly_en_i) |-> pin_o);

    // R9: no pin change while logic and pin agree
    a_r9_hold_when_equal: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pin_o) == $past(logic_o)) |-> $stable(pin_o));

    // R6: a latch only drops after a clear
    a_r6_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(lat_q) & ~lat_q) != '0) |-> $past(clr_any));
endmodule

bind sop_gpo_top sop_gpo_chk #(.W(NUM_TYPES * N_RAIL)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .logic_o         (logic_o),
    .pin_o           (pin_o),
    .cfg_on_dly_en_i (cfg_on_dly_en_i),
    .lat_q           (lat_q),
    .clr_any         (clr_any)
);

// File: tb/sop_gpo_top_tb.sv
// Bench: directed corner cases, then seeded random stimulus, compared each
// cycle against a cycle-level model written from the requirements.
module sop_gpo_top_tb;
    localparam int NG = 8;
    localparam int NI = 3;
    localparam int NR = 3;
    localparam int NT = 6;
    localparam int FW = NT * NR;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic [NG-1:0]   gpo_st = '0;
    logic [NI-1:0]   gpi = '0;
    logic [FW-1:0]   flags = '0;
    logic [NR-1:0]   vmon = '0;
    logic            lclr = 1'b0;
    logic [2*NG-1:0] gpo_en = '0, gpo_inv = '0;
    logic [2*NI-1:0] gpi_en = '0, gpi_inv = '0;
    logic [2*NR-1:0] rmask = '0, rinv = '0;
    logic [9:0]      tsel = '0;
    logic            clr_en = 1'b0;
    logic [3:0]      clr_sel = '0;
    logic [15:0]     on_dly = '0, off_dly = '0;
    logic            on_en = 1'b0, off_en = 1'b0;
    logic            logic_o, pin_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [FW-1:0] m_lat, m_prev;
    logic          m_logic, m_pin;
    int            m_cnt;

    always #4 clk = ~clk;

    sop_gpo_top #(.N_GPO(NG), .N_GPI(NI), .N_RAIL(NR), .NUM_TYPES(NT)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_1ms_i(tick),
        .gpo_state_i(gpo_st), .gpi_i(gpi), .rail_flags_i(flags),
        .rail_vmon_i(vmon), .latch_clr_i(lclr),
        .cfg_gpo_en_i(gpo_en), .cfg_gpo_inv_i(gpo_inv),
        .cfg_gpi_en_i(gpi_en), .cfg_gpi_inv_i(gpi_inv),
        .cfg_rail_mask_i(rmask), .cfg_rail_inv_i(rinv),
        .cfg_type_sel_i(tsel), .cfg_clr_gpi_en_i(clr_en),
        .cfg_clr_gpi_sel_i(clr_sel), .cfg_on_dly_i(on_dly),
        .cfg_off_dly_i(off_dly), .cfg_on_dly_en_i(on_en),
        .cfg_off_dly_en_i(off_en), .logic_o(logic_o), .pin_o(pin_o)
    );

    function automatic logic eval_term(int t);
        logic any_en, all_ok, f, want_lat;
        int idx;
        any_en = 1'b0;
        all_ok = 1'b1;
        for (int i = 0; i < NG; i++)
            if (gpo_en[t*NG+i]) begin
                any_en = 1'b1;
                if ((gpo_st[i] ^ gpo_inv[t*NG+i]) == 1'b0) all_ok = 1'b0;
            end
        for (int i = 0; i < NI; i++)
            if (gpi_en[t*NI+i]) begin
                any_en = 1'b1;
                if ((gpi[i] ^ gpi_inv[t*NI+i]) == 1'b0) all_ok = 1'b0;
            end
        idx = int'(tsel[t*5 +: 4]);
        want_lat = tsel[t*5+4];
        for (int r = 0; r < NR; r++)
            if (rmask[t*NR+r] && !(idx == 0 && !vmon[r])) begin
                any_en = 1'b1;
                f = 1'b0;
                if (idx < NT) f = want_lat ? m_lat[idx*NR+r] : flags[idx*NR+r];
                if ((f ^ rinv[t*NR+r]) == 1'b0) all_ok = 1'b0;
            end
        return any_en && all_ok;
    endfunction

    task automatic model_reset();
        m_lat = '0; m_prev = '0; m_logic = 1'b0; m_pin = 1'b0; m_cnt = 0;
    endtask

    // Next model state from the inputs the DUT samples at the coming edge.
    task automatic model_step();
        logic nl, clr, d_en;
        int d;
        clr = lclr | (clr_en && (int'(clr_sel) < NI) && gpi[clr_sel[1:0]]);
        nl = eval_term(0) | eval_term(1);
        if (m_logic == m_pin) m_cnt = 0;
        else begin
            d_en = m_logic ? on_en : off_en;
            d    = m_logic ? int'(on_dly) : int'(off_dly);
            if (!d_en || d == 0) begin m_pin = m_logic; m_cnt = 0; end
            else if (tick) begin
                if (m_cnt + 1 >= d) begin m_pin = m_logic; m_cnt = 0; end
                else m_cnt = m_cnt + 1;
            end
        end
        m_lat   = (m_lat & ~{FW{clr}}) | (flags & ~m_prev);
        m_prev  = flags;
        m_logic = nl;
    endtask

    task automatic check(string req, string what, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic cycle(string req);
        model_step();
        @(posedge clk);
        @(negedge clk);
        check(req, "logic_o", logic_o, m_logic);
        check(req, "pin_o", pin_o, m_pin);
    endtask

    task automatic cycles(string req, int n);
        for (int i = 0; i < n; i++) cycle(req);
    endtask

    task automatic cfg_clear();
        gpo_en = '0; gpo_inv = '0; gpi_en = '0; gpi_inv = '0;
        rmask = '0; rinv = '0; tsel = '0; clr_en = 1'b0; clr_sel = '0;
        on_dly = '0; off_dly = '0; on_en = 1'b0; off_en = 1'b0;
        gpi = '0; gpo_st = '0; flags = '0; lclr = 1'b0; tick = 1'b0;
    endtask

    task automatic cfg_random();
        gpo_en  = 16'($urandom & $urandom);  gpo_inv = 16'($urandom);
        gpi_en  = 6'($urandom & $urandom);   gpi_inv = 6'($urandom);
        rmask   = 6'($urandom & $urandom);   rinv    = 6'($urandom);
        tsel    = 10'($urandom);
        vmon    = 3'($urandom);
        clr_en  = 1'($urandom);  clr_sel = 4'($urandom_range(0, 3));
        on_dly  = 16'($urandom_range(0, 4)); off_dly = 16'($urandom_range(0, 4));
        on_en   = 1'($urandom);  off_en  = 1'($urandom);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state seen at the ports
        check("R1", "logic_o", logic_o, 1'b0);
        check("R1", "pin_o", pin_o, 1'b0);
        cycles("R1", 2);

        // R3: empty terms stay 0 even with every invert set
        gpo_inv = '1; gpi_inv = '1; rinv = '1; gpi = '1;
        cycles("R3", 3);
        // R2: a single-input term B drives the output
        cfg_clear(); gpo_en[NG+2] = 1'b1; gpo_st[2] = 1'b1;
        cycles("R2", 3);
        gpo_st[2] = 1'b0;
        cycles("R2", 2);

        // R5: unmonitored power-good rail is skipped
        cfg_clear(); gpi_en[0] = 1'b1; gpi[0] = 1'b1; rmask[0] = 1'b1;
        tsel[4:0] = 5'b00000; vmon = 3'b000;
        cycles("R5", 3);
        vmon[0] = 1'b1;
        cycles("R5", 3);

        // R4: out-of-range type reads 0; in-range live type is used
        cfg_clear(); rmask[1] = 1'b1; tsel[4:0] = 5'd7; rinv[1] = 1'b1;
        cycles("R4", 3);
        rinv[1] = 1'b0;
        cycles("R4", 2);
        tsel[4:0] = 5'd3; flags[3*NR+1] = 1'b1;
        cycles("R4", 3);

        // R6: latched type holds after the live pulse
        cfg_clear(); rmask[2] = 1'b1; tsel[4:0] = 5'b10010;
        flags[2*NR+2] = 1'b1; cycle("R6");
        flags[2*NR+2] = 1'b0; cycles("R6", 5);
        // R7: strobe clear
        lclr = 1'b1; cycle("R7"); lclr = 1'b0; cycles("R7", 3);
        // R7: clear through an input pin
        flags[2*NR+2] = 1'b1; cycle("R6"); flags[2*NR+2] = 1'b0; cycles("R6", 2);
        clr_en = 1'b1; clr_sel = 4'd3; gpi[1] = 1'b1; cycles("R7", 3);
        clr_sel = 4'd1; cycle("R7"); gpi[1] = 1'b0; clr_en = 1'b0; cycles("R7", 3);
        // R7: rise on the clear edge wins
        lclr = 1'b1; flags[2*NR+2] = 1'b1; cycle("R7");
        lclr = 1'b0; flags[2*NR+2] = 1'b0; cycles("R7", 3);

        // R10 and R8: delayed pin, undelayed logic
        cfg_clear(); gpi_en[0] = 1'b1;
        on_dly = 16'd3; off_dly = 16'd2; on_en = 1'b1; off_en = 1'b1;
        gpi[0] = 1'b1; cycles("R10", 3);
        for (int i = 0; i < 10; i++) begin tick = ~tick; cycle("R8"); end
        gpi[0] = 1'b0;
        for (int i = 0; i < 10; i++) begin tick = ~tick; cycle("R8"); end
        // R9: short pulse shorter than the delay never reaches the pin
        on_dly = 16'd5; tick = 1'b1; gpi[0] = 1'b1; cycles("R9", 3);
        gpi[0] = 1'b0; cycles("R9", 8);
        // R8: zero delay passes on the next edge
        on_dly = 16'd0; tick = 1'b0; gpi[0] = 1'b1; cycles("R8", 3);
        gpi[0] = 1'b0; cycles("R8", 6);

        // R2: random mix
        cfg_clear();
        for (int n = 0; n < 3000; n++) begin
            if (n % 40 == 0) cfg_random();
            for (int b = 0; b < FW; b++) if ($urandom_range(0, 7) == 0) flags[b] = ~flags[b];
            for (int b = 0; b < NI; b++) if ($urandom_range(0, 5) == 0) gpi[b] = ~gpi[b];
            for (int b = 0; b < NG; b++) if ($urandom_range(0, 5) == 0) gpo_st[b] = ~gpo_st[b];
            lclr = ($urandom_range(0, 39) == 0);
            tick = ($urandom_range(0, 2) == 0);
            cycle("R2");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule